// File: doc/BRIEF.md
# Diagonal Complex Coefficient Multiplier

This block rotates each element of a vector of complex samples by a fixed complex coefficient of its own. The coefficient is chosen by the element's position. The effect is a diagonal matrix applied to the whole vector in one pass. Every coefficient has unit modulus and is stored as signed 8-bit real and imaginary parts scaled by 128. The block can therefore act either as a phase-only channel model or as the precoder that undoes it.

A parameter selects the coefficient set. With the channel set, element k is rotated by the angle (k mod 8 + 1)·π/6. With the conjugate set, every angle is negated. Each lane forms the complex product with four real multiplies and two add/subtract operations. It then removes the ×128 scale with round-to-nearest. A conjugate instance followed by a channel instance returns the input vector to within a couple of LSBs.

A vector is accepted on any cycle with the valid flag high. Full throughput is one vector per cycle, with a fixed latency.

Top module: `dcm_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and every output component is 0.
- R2: `out_valid` is high exactly three clock cycles after a cycle with `in_valid` high, and low otherwise. Back-to-back input vectors produce back-to-back output vectors.
- R3: For lane k, the result is computed from the input a = ar + j·ai and the coefficient c = cr + j·ci. The real output is the rounded value of (ar·cr − ai·ci)/128. The imaginary output is the rounded value of (ar·ci + ai·cr)/128.
- R4: For a sum s, rounding gives floor(s/128) plus bit 6 of s in two's complement. Exact halves therefore go toward +infinity: s = −8128 gives −63 and s = 8128 gives 64.
- R5: With `CONJ`=0, lane k uses the coefficient at index k mod 8 of the following table:
  - real parts (cr): 111, 64, 0, −64, −111, −128, −111, −64
  - imaginary parts (ci): 64, 111, 127, 111, 64, 0, −64, −111
- R6: With `CONJ`=1, every lane uses the same real part as in R5 and the negated imaginary part.
- R7: While `out_valid` is low, all output components keep their previous values.
- R8: A `CONJ`=1 instance fed with components in [−40, 40], followed by a `CONJ`=0 instance, returns every component within ±2 of the original input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector valid |
| in_re | input | N*W | Real parts of the input, lane k at bits [k*W +: W], signed |
| in_im | input | N*W | Imaginary parts of the input, same packing as `in_re` |
| out_valid | output | 1 | Output vector valid |
| out_re | output | N*(W+2) | Real parts of the output, lane k at bits [k*(W+2) +: W+2], signed |
| out_im | output | N*(W+2) | Imaginary parts of the output, same packing as `out_re` |

## Verification
The bench compares every output on every cycle, so faults show up quickly:
- A wrong coefficient or a swapped product term shows as a wrong value in one lane on the first valid vector that has a nonzero component in that lane.
- A missing rounding bit shows as an error of one LSB on roughly half of all results.
- A fault in the valid pipeline shows as a mistimed `out_valid` three cycles after the input, or as outputs drifting while `out_valid` is low.
- Slow coefficient or rounding bias is caught by the cascade check once it builds up beyond two LSBs.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  // Pipeline depth from input to output
  localparam int LAT = 3;
  // Coefficient scale is 2**CSH
  localparam int CSH = 7;
  localparam int CW  = 8;

  // Quantized e^(j(k+1)pi/6), real part
  function automatic logic signed [CW-1:0] coef_re(input int k);
    logic signed [CW-1:0] v;
    case (k % 8)
      0: v = 8'sd111;
      1: v = 8'sd64;
      2: v = 8'sd0;
      3: v = -8'sd64;
      4: v = -8'sd111;
      5: v = -8'sd128;
      6: v = -8'sd111;
      default: v = -8'sd64;
    endcase
    return v;
  endfunction

  // Imaginary part; conj negates it
  function automatic logic signed [CW-1:0] coef_im(input int k, input bit conj);
    logic signed [CW-1:0] v;
    case (k % 8)
      0: v = 8'sd64;
      1: v = 8'sd111;
      2: v = 8'sd127;
      3: v = 8'sd111;
      4: v = 8'sd64;
      5: v = 8'sd0;
      6: v = -8'sd64;
      default: v = -8'sd111;
    endcase
    return conj ? -v : v;
  endfunction

endpackage

// File: rtl/dcm_valid_pipe.sv
module dcm_valid_pipe
  import dcm_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic [LAT-1:0] stage_v
);

  always_ff @(posedge clk) begin
    if (rst) stage_v <= '0;
    else     stage_v <= {stage_v[LAT-2:0], in_valid};
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    stage_v[LAT-1] |-> $past(in_valid, LAT));

endmodule

// File: rtl/dcm_rounder.sv
module dcm_rounder
  import dcm_pkg::*;
#(
  parameter int SW = 21,
  localparam int OW = SW - CSH
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [SW-1:0] s,
  output logic signed [OW-1:0] y
);

  logic [CSH-2:0] unused_lo;
  assign unused_lo = s[CSH-2:0];

  logic signed [OW-1:0] trunc;
  logic [OW-1:0]        half;
  assign trunc = s[SW-1:CSH];
  assign half  = {{(OW-1){1'b0}}, s[CSH-1]};

  always_ff @(posedge clk) begin
    if (rst)     y <= '0;
    else if (en) y <= trunc + $signed(half);
  end

endmodule

// File: rtl/dcm_lane.sv
module dcm_lane
  import dcm_pkg::*;
#(
  parameter int W    = 12,
  parameter int IDX  = 0,
  parameter bit CONJ = 1'b0,
  localparam int PW  = W + CW,
  localparam int SW  = PW + 1,
  localparam int OW  = SW - CSH
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                en1,
  input  logic                en2,
  input  logic                en3,
  input  logic                vo,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  output logic signed [OW-1:0] y_re,
  output logic signed [OW-1:0] y_im
);

  localparam logic signed [CW-1:0] C_RE = coef_re(IDX);
  localparam logic signed [CW-1:0] C_IM = coef_im(IDX, CONJ);

  logic signed [PW-1:0] ar_x, ai_x, cr_x, ci_x;
  assign ar_x = {{CW{a_re[W-1]}}, a_re};
  assign ai_x = {{CW{a_im[W-1]}}, a_im};
  assign cr_x = {{W{C_RE[CW-1]}}, C_RE};
  assign ci_x = {{W{C_IM[CW-1]}}, C_IM};

  // Stage 1: four partial products
  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
  always_ff @(posedge clk) begin
    if (rst) begin
      p_rr <= '0; p_ii <= '0; p_ri <= '0; p_ir <= '0;
    end else if (en1) begin
      p_rr <= ar_x * cr_x;
      p_ii <= ai_x * ci_x;
      p_ri <= ar_x * ci_x;
      p_ir <= ai_x * cr_x;
    end
  end

  // Stage 2: combine into full-precision sums
  logic signed [SW-1:0] s_re, s_im;
  always_ff @(posedge clk) begin
    if (rst) begin
      s_re <= '0; s_im <= '0;
    end else if (en2) begin
      s_re <= {p_rr[PW-1], p_rr} - {p_ii[PW-1], p_ii};
      s_im <= {p_ri[PW-1], p_ri} + {p_ir[PW-1], p_ir};
    end
  end

  // Stage 3: drop the scale with rounding
  dcm_rounder #(.SW(SW)) u_rnd_re (.clk(clk), .rst(rst), .en(en3), .s(s_re), .y(y_re));
  dcm_rounder #(.SW(SW)) u_rnd_im (.clk(clk), .rst(rst), .en(en3), .s(s_im), .y(y_im));

  // R3
  zero_in_chk: assert property (@(posedge clk) disable iff (rst)
    (en1 && a_re == '0) |=> (p_rr == '0 && p_ri == '0));

  // R4
  round_near_chk: assert property (@(posedge clk) disable iff (rst)
    $past(en3) |-> (($signed({y_re, {CSH{1'b0}}}) - $past(s_re) > -64) &&
                    ($signed({y_re, {CSH{1'b0}}}) - $past(s_re) <= 64)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vo |-> ($stable(y_re) && $stable(y_im)));

endmodule

// File: rtl/dcm_top.sv
module dcm_top
  import dcm_pkg::*;
#(
  parameter int N    = 8,
  parameter int W    = 12,
  parameter bit CONJ = 1'b0,
  localparam int OW  = W + 2
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [N*W-1:0]  in_re,
  input  logic [N*W-1:0]  in_im,
  output logic            out_valid,
  output logic [N*OW-1:0] out_re,
  output logic [N*OW-1:0] out_im
);

  logic [LAT-1:0] stage_v;

  dcm_valid_pipe u_vp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .stage_v(stage_v)
  );

  assign out_valid = stage_v[LAT-1];

  for (genvar k = 0; k < N; k++) begin : g_lane
    logic signed [OW-1:0] yr, yi;
    dcm_lane #(.W(W), .IDX(k), .CONJ(CONJ)) u_lane (
      .clk (clk),
      .rst (rst),
      .en1 (in_valid),
      .en2 (stage_v[0]),
      .en3 (stage_v[1]),
      .vo  (stage_v[2]),
      .a_re(in_re[k*W +: W]),
      .a_im(in_im[k*W +: W]),
      .y_re(yr),
      .y_im(yi)
    );
    assign out_re[k*OW +: OW] = yr;
    assign out_im[k*OW +: OW] = yi;
  end

endmodule

// File: tb/sim_dcm_top.sv
module sim_dcm_top;

  localparam int N  = 8;
  localparam int W  = 12;
  localparam int OW = W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // u0: channel set, full range; u1: conjugate set, small range; u2 follows u1
  logic            v0 = 1'b0, v1 = 1'b0;
  logic [N*W-1:0]  r0 = '0, i0 = '0, r1 = '0, i1 = '0;
  logic            ov0, ov1, ov2;
  logic [N*OW-1:0] or0, oi0, or1, oi1, or2, oi2;
  logic [N*W-1:0]  r2, i2;

  dcm_top #(.N(N), .W(W), .CONJ(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_valid(v0), .in_re(r0), .in_im(i0),
    .out_valid(ov0), .out_re(or0), .out_im(oi0));
  dcm_top #(.N(N), .W(W), .CONJ(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(v1), .in_re(r1), .in_im(i1),
    .out_valid(ov1), .out_re(or1), .out_im(oi1));

  for (genvar k = 0; k < N; k++) begin : g_cut
    assign r2[k*W +: W] = or1[k*OW +: W];
    assign i2[k*W +: W] = oi1[k*OW +: W];
  end

  dcm_top #(.N(N), .W(W), .CONJ(1'b0)) u2 (
    .clk(clk), .rst(rst), .in_valid(ov1), .in_re(r2), .in_im(i2),
    .out_valid(ov2), .out_re(or2), .out_im(oi2));

  // Coefficient table from R5
  int cr[8] = '{111, 64, 0, -64, -111, -128, -111, -64};
  int ci[8] = '{64, 111, 127, 111, 64, 0, -64, -111};

  int errors = 0;
  int checks = 0;
  string phase = "R1";

  function automatic int rnd128(input int s);
    return (s >>> 7) + ((s >>> 6) & 1);
  endfunction

  // Reference model: 3-deep expected pipeline per instance
  bit pv[2][3];
  int pre[2][3][N];
  int pim[2][3][N];
  int lre[2][N];
  int lim[2][N];
  logic [2*N*W-1:0] cq[$];

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      for (int d = 2; d > 0; d--) begin
        pv[m][d] = pv[m][d-1];
        for (int k = 0; k < N; k++) begin
          pre[m][d][k] = pre[m][d-1][k];
          pim[m][d][k] = pim[m][d-1][k];
        end
      end
      pv[m][0] = rst ? 1'b0 : (m == 0 ? v0 : v1);
      for (int k = 0; k < N; k++) begin
        int ar, ai, c_i;
        ar  = $signed(m == 0 ? r0[k*W +: W] : r1[k*W +: W]);
        ai  = $signed(m == 0 ? i0[k*W +: W] : i1[k*W +: W]);
        c_i = (m == 0) ? ci[k%8] : -ci[k%8];
        pre[m][0][k] = rnd128(ar*cr[k%8] - ai*c_i);
        pim[m][0][k] = rnd128(ar*c_i + ai*cr[k%8]);
      end
      if (rst) begin
        for (int d = 0; d < 3; d++) pv[m][d] = 1'b0;
        for (int k = 0; k < N; k++) begin lre[m][k] = 0; lim[m][k] = 0; end
      end else if (pv[m][2]) begin
        for (int k = 0; k < N; k++) begin
          lre[m][k] = pre[m][2][k];
          lim[m][k] = pim[m][2][k];
        end
      end
    end
    if (!rst && v1) cq.push_back({r1, i1});
  end

  // Per-cycle comparison, away from the active edge
  bit run_chk = 1'b0;
  always @(negedge clk) begin
    if (run_chk) begin
      for (int m = 0; m < 2; m++) begin
        logic ov;
        ov = (m == 0) ? ov0 : ov1;
        checks++;
        if (ov !== pv[m][2]) begin
          errors++;
          $display("FAIL R2 %s u%0d out_valid act=%0b exp=%0b", phase, m, ov, pv[m][2]);
        end
        for (int k = 0; k < N; k++) begin
          int are, aim;
          are = $signed(m == 0 ? or0[k*OW +: OW] : or1[k*OW +: OW]);
          aim = $signed(m == 0 ? oi0[k*OW +: OW] : oi1[k*OW +: OW]);
          checks++;
          if (are != lre[m][k] || aim != lim[m][k]) begin
            errors++;
            $display("FAIL %s %s u%0d lane%0d act=(%0d,%0d) exp=(%0d,%0d)",
                     phase, (m == 0) ? "R5" : "R6", m, k, are, aim, lre[m][k], lim[m][k]);
          end
        end
      end
      if (ov2) begin
        logic [2*N*W-1:0] ref_v;
        ref_v = cq.pop_front();
        for (int k = 0; k < N; k++) begin
          int xr, xi, yr, yi;
          xr = $signed(ref_v[N*W + k*W +: W]);
          xi = $signed(ref_v[k*W +: W]);
          yr = $signed(or2[k*OW +: OW]);
          yi = $signed(oi2[k*OW +: OW]);
          checks++;
          if (yr - xr > 2 || xr - yr > 2 || yi - xi > 2 || xi - yi > 2) begin
            errors++;
            $display("FAIL R8 lane%0d act=(%0d,%0d) exp=(%0d,%0d)+-2", k, yr, yi, xr, xi);
          end
        end
      end
    end
  end

  task automatic step(input bit va, input bit vb, input int mode);
    @(negedge clk);
    v0 = va;
    v1 = vb;
    for (int k = 0; k < N; k++) begin
      int a, b;
      case (mode)
        0: begin a = $urandom_range(4095) - 2048; b = $urandom_range(4095) - 2048; end
        1: begin a = 2047;  b = -2048; end
        2: begin a = -2048; b = 2047;  end
        3: begin a = 0;     b = (k == 2) ? 64 : 0; end
        4: begin a = 0;     b = (k == 2) ? -64 : 0; end
        default: begin a = (k == mode % N) ? 1000 : 0; b = 0; end
      endcase
      r0[k*W +: W] = a[W-1:0];
      i0[k*W +: W] = b[W-1:0];
      a = $urandom_range(80) - 40;
      b = $urandom_range(80) - 40;
      r1[k*W +: W] = a[W-1:0];
      i1[k*W +: W] = b[W-1:0];
    end
  endtask

  task automatic finish_run();
    checks++;
    if (cq.size() != 0) begin
      errors++;
      $display("FAIL R8 pending vectors act=%0d exp=0", cq.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    checks++;
    if (ov0 !== 1'b0 || or0 !== '0 || oi0 !== '0) begin
      errors++;
      $display("FAIL R1 reset state act=%0b exp=0", ov0);
    end
    @(negedge clk);
    rst = 1'b0;
    run_chk = 1'b1;

    phase = "R3";
    for (int n = 0; n < 200; n++) step(1'b1, 1'b1, 0);
    step(1'b1, 1'b1, 1);
    step(1'b1, 1'b1, 2);
    for (int n = 0; n < 8; n++) step(1'b1, 1'b1, 8 + n);

    phase = "R7";
    for (int n = 0; n < 300; n++) step($urandom_range(1) == 1, $urandom_range(2) == 0, 0);
    for (int n = 0; n < 6; n++) step(1'b0, 1'b0, 0);

    phase = "R4";
    step(1'b1, 1'b0, 3);
    for (int n = 0; n < 4; n++) step(1'b0, 1'b0, 0);
    @(negedge clk);
    checks++;
    if ($signed(or0[2*OW +: OW]) != -63) begin
      errors++;
      $display("FAIL R4 lane2 re act=%0d exp=-63", $signed(or0[2*OW +: OW]));
    end
    step(1'b1, 1'b0, 4);
    for (int n = 0; n < 4; n++) step(1'b0, 1'b0, 0);
    @(negedge clk);
    checks++;
    if ($signed(or0[2*OW +: OW]) != 64) begin
      errors++;
      $display("FAIL R4 lane2 re act=%0d exp=64", $signed(or0[2*OW +: OW]));
    end

    phase = "R2";
    for (int n = 0; n < 50; n++) step(n % 3 != 0, 1'b1, 0);
    for (int n = 0; n < 10; n++) step(1'b0, 1'b0, 0);
    finish_run();
  end

endmodule